// File: doc/BRIEF.md
# Level-Gated Pulse Width Timer

This block is a down-counting timer pair. The low channel can measure how long an external pin stays at a chosen level. A prescaler tick drives the low counter, but only while the synchronized pin matches the selected polarity. Each such tick lowers the count by one. Software loads a start value and raises the run bit. It later reads the remaining count, and the width in ticks is the start value minus that count.

With measurement disabled, the low channel counts every tick like an ordinary timer. In 8-bit mode the high channel is always an independent ordinary timer. In 16-bit mode the two counters form a single measurement channel under the low channel's controls. When a counter is at zero on a gated tick, it reloads and raises a one-cycle underflow flag, which exposes a pulse too long for the chosen range.

Top module: `pulse_width_timer`

## Requirements
- R1: After reset, both counts are 0 and both underflow flags are 0.
- R2: A rising edge of a channel's run bit loads that channel's reload value into its counter on that clock edge. In 16-bit mode, a rise of `run_lo` loads `{reload_hi, reload_lo}`. The load takes priority over counting.
- R3: With `meas_en` = 1 and `pol` = 0, the low channel decrements on a tick only while the synchronized pin is 0. With `pol` = 1, it decrements only while the synchronized pin is 1.
- R4: The pin passes through two flops before it gates the count. A change of the pin made between two clock edges alters gating from the third following clock edge onward.
- R5: With `meas_en` = 0, the low channel decrements on every tick, whatever the pin level.
- R6: While a channel's run bit is 0, its count holds, whatever the tick and pin do.
- R7: A counted tick at count 0 reloads the counter and sets its underflow flag for exactly that one cycle. Without a further counted tick at zero, the flag returns to 0 the next cycle.
- R8: With `wide` = 0, the high channel decrements on every tick while `run_hi` = 1, reloads from `reload_hi`, and ignores the pin.
- R9: With `wide` = 1, `{count_hi, count_lo}` acts as one 16-bit gated counter with borrow from low to high. It underflows only at 0x0000, which is reported on `uf_lo`, and `uf_hi` stays 0. `run_hi` has no effect in this mode.
- R10: A cycle without `tick` never changes a running counter, except for a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaler count enable, one cycle per tick |
| pin | input | 1 | External level to be measured (asynchronous) |
| pol | input | 1 | Level that opens the gate: 0 low, 1 high |
| meas_en | input | 1 | 1 gates the low channel by the pin level |
| wide | input | 1 | 1 joins the two channels into a 16-bit counter |
| run_lo | input | 1 | Run bit of the low channel (and of the 16-bit pair) |
| run_hi | input | 1 | Run bit of the high channel in 8-bit mode |
| reload_lo | input | W | Reload value of the low channel |
| reload_hi | input | W | Reload value of the high channel |
| count_lo | output | W | Low channel count |
| count_hi | output | W | High channel count |
| uf_lo | output | 1 | Underflow pulse of the low channel or the pair |
| uf_hi | output | 1 | Underflow pulse of the high channel (8-bit mode only) |

## Verification
The assertions assume that the control inputs (`pol`, `meas_en`, `wide`, the run bits and the reload values) change only between clock edges and stay stable across each edge. They also assume that `tick` is a single-cycle-qualified enable. Only the pin is treated as asynchronous, and it is checked through the synchronized level that gates the count. The stimulus drives every input, the pin included, on the falling clock edge. It switches `wide` only while the pair is stopped and then restarts it with a rising run bit, so every gating and hold property starts from a defined load.

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         pin,
  input  logic         pol,
  input  logic         meas_en,
  input  logic         wide,
  input  logic         run_lo,
  input  logic         run_hi,
  input  logic [W-1:0] reload_lo,
  input  logic [W-1:0] reload_hi,
  output logic [W-1:0] count_lo,
  output logic [W-1:0] count_hi,
  output logic         uf_lo,
  output logic         uf_hi
);
  localparam int DW = 2 * W;

  logic s1, s2, rq_lo, rq_hi;

  wire          gate    = tick & run_lo & (~meas_en | (s2 == pol));
  wire          tick_hi = tick & run_hi;
  wire          ld_lo   = run_lo & ~rq_lo;
  wire          ld_hi   = run_hi & ~rq_hi;
  wire [DW-1:0] pair    = {count_hi, count_lo};
  wire [DW-1:0] rl_pair = {reload_hi, reload_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      rq_lo <= 1'b0;
      rq_hi <= 1'b0;
    end else begin
      s1    <= pin;
      s2    <= s1;
      rq_lo <= run_lo;
      rq_hi <= run_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_lo <= '0;
      count_hi <= '0;
      uf_lo    <= 1'b0;
      uf_hi    <= 1'b0;
    end else begin
      uf_lo <= 1'b0;
      uf_hi <= 1'b0;
      if (wide) begin
        if (ld_lo) begin
          {count_hi, count_lo} <= rl_pair;
        end else if (gate) begin
          if (pair == '0) begin
            {count_hi, count_lo} <= rl_pair;
            uf_lo <= 1'b1;
          end else begin
            {count_hi, count_lo} <= pair - 1'b1;
          end
        end
      end else begin
        if (ld_lo) begin
          count_lo <= reload_lo;
        end else if (gate) begin
          if (count_lo == '0) begin
            count_lo <= reload_lo;
            uf_lo    <= 1'b1;
          end else begin
            count_lo <= count_lo - 1'b1;
          end
        end
        if (ld_hi) begin
          count_hi <= reload_hi;
        end else if (tick_hi) begin
          if (count_hi == '0) begin
            count_hi <= reload_hi;
            uf_hi    <= 1'b1;
          end else begin
            count_hi <= count_hi - 1'b1;
          end
        end
      end
    end
  end
endmodule

module pulse_width_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         pol,
  input logic         meas_en,
  input logic         wide,
  input logic         run_lo,
  input logic         run_hi,
  input logic         s2,
  input logic         rq_lo,
  input logic [W-1:0] count_lo,
  input logic [W-1:0] count_hi,
  input logic         uf_lo,
  input logic         uf_hi
);
  assert_gate_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_en && run_lo && rq_lo && (s2 != pol)) |=> $stable(count_lo));

  assert_stopped_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_lo |=> $stable(count_lo));

  assert_no_tick_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && run_lo && rq_lo) |=> $stable(count_lo));

  assert_uf_from_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uf_lo) |-> ($past(tick) && $past(count_lo) == '0));

  assert_hi_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !run_hi) |=> $stable(count_hi));

  assert_wide_no_uf_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> !uf_hi);
endmodule

bind pulse_width_timer pulse_width_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pol(pol), .meas_en(meas_en),
  .wide(wide), .run_lo(run_lo), .run_hi(run_hi), .s2(s2), .rq_lo(rq_lo),
  .count_lo(count_lo), .count_hi(count_hi), .uf_lo(uf_lo), .uf_hi(uf_hi)
);

// File: tb/tb_pulse_width_timer.sv
`timescale 1ns/1ps
module tb_pulse_width_timer;
  logic clk = 0, rst_n = 0, tick = 0, pin = 1, pol = 0, meas_en = 1, wide = 0;
  logic run_lo = 0, run_hi = 0;
  logic [7:0] reload_lo = 0, reload_hi = 0;
  logic [7:0] count_lo, count_hi;
  logic uf_lo, uf_hi;

  pulse_width_timer dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_lo = 0, m_hi = 0, m_pair;
  bit m_s1 = 0, m_s2 = 0, m_rql = 0, m_rqh = 0, m_ufl = 0, m_ufh = 0, g;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_s1 = 0; m_s2 = 0; m_rql = 0; m_rqh = 0; m_ufl = 0; m_ufh = 0;
    end else begin
      g = tick && run_lo && (!meas_en || (m_s2 == pol));
      m_ufl = 0; m_ufh = 0;
      if (wide) begin
        m_pair = m_hi * 256 + m_lo;
        if (run_lo && !m_rql) m_pair = reload_hi * 256 + reload_lo;
        else if (g) begin
          if (m_pair == 0) begin m_pair = reload_hi * 256 + reload_lo; m_ufl = 1; end
          else m_pair = m_pair - 1;
        end
        m_hi = m_pair / 256; m_lo = m_pair % 256;
      end else begin
        if (run_lo && !m_rql) m_lo = reload_lo;
        else if (g) begin
          if (m_lo == 0) begin m_lo = reload_lo; m_ufl = 1; end else m_lo = m_lo - 1;
        end
        if (run_hi && !m_rqh) m_hi = reload_hi;
        else if (tick && run_hi) begin
          if (m_hi == 0) begin m_hi = reload_hi; m_ufh = 1; end else m_hi = m_hi - 1;
        end
      end
      m_s2 = m_s1; m_s1 = pin; m_rql = run_lo; m_rqh = run_hi;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk({cur_req, " model count_lo"}, count_lo, m_lo);
    chk({cur_req, " model count_hi"}, count_hi, m_hi);
    chk({cur_req, " model uf_lo"}, uf_lo, m_ufl);
    chk({cur_req, " model uf_hi"}, uf_hi, m_ufh);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1;
    chk("R1 count_lo", count_lo, 0); chk("R1 count_hi", count_hi, 0);
    chk("R1 uf_lo", uf_lo, 0); chk("R1 uf_hi", uf_hi, 0);

    cur_req = "R2"; reload_lo = 8'h50; run_lo = 1; cyc(1);
    chk("R2 load on run rise", count_lo, 8'h50);

    cur_req = "R3"; pin = 0; cyc(3); tick = 1; cyc(10); tick = 0;
    chk("R3 low counted pol0", count_lo, 8'h46);
    pin = 1; cyc(3); tick = 1; cyc(10); tick = 0;
    chk("R3 high ignored pol0", count_lo, 8'h46);
    pol = 1; tick = 1; cyc(6); tick = 0;
    chk("R3 high counted pol1", count_lo, 8'h40);

    cur_req = "R4"; tick = 1; pin = 0; cyc(4); tick = 0;
    chk("R4 two-stage sync delay", count_lo, 8'h3E);

    cur_req = "R10"; pol = 0; cyc(5);
    chk("R10 no tick no change", count_lo, 8'h3E);

    cur_req = "R5"; meas_en = 0; pin = 1; cyc(3); tick = 1; cyc(5); tick = 0;
    chk("R5 ungated timer", count_lo, 8'h39);
    meas_en = 1;

    cur_req = "R6"; run_lo = 0; pin = 0; cyc(3); tick = 1; cyc(5); tick = 0;
    chk("R6 stopped holds", count_lo, 8'h39);

    cur_req = "R7"; reload_lo = 3; run_lo = 1; cyc(1);
    chk("R7 reload", count_lo, 3);
    tick = 1; cyc(3);
    chk("R7 reached zero", count_lo, 0); chk("R7 no flag yet", uf_lo, 0);
    cyc(1);
    chk("R7 underflow flag", uf_lo, 1); chk("R7 reloaded", count_lo, 3);
    tick = 0; cyc(1);
    chk("R7 flag one cycle", uf_lo, 0);

    cur_req = "R8"; reload_hi = 8'h20; run_hi = 1; pin = 1; cyc(3);
    tick = 1; cyc(4); tick = 0;
    chk("R8 hi ordinary timer", count_hi, 8'h1C);
    chk("R8 lo still gated (R3)", count_lo, 3);

    cur_req = "R9"; run_lo = 0; run_hi = 0; cyc(1);
    wide = 1; reload_hi = 1; reload_lo = 0; pin = 0; cyc(3); run_lo = 1; cyc(1);
    chk("R9 pair load", {count_hi, count_lo}, 16'h0100);
    tick = 1; cyc(1); tick = 0;
    chk("R9 borrow", {count_hi, count_lo}, 16'h00FF);
    run_lo = 0; cyc(1); reload_hi = 0; run_lo = 1; cyc(1);
    chk("R9 pair zero", {count_hi, count_lo}, 0);
    tick = 1; cyc(1); tick = 0;
    chk("R9 uf_lo on pair", uf_lo, 1); chk("R9 uf_hi quiet", uf_hi, 0);
    cyc(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule